// File: doc/BRIEF.md
# One-Shot OTG Timeout Timer

This block is a single 32-bit control/value register with a one-shot countdown behind it. Software writes the register to arm or disarm the timer. When the top bit of the written word is set, the low 27 bits give a count of device clock ticks, and a countdown starts from that count. When the countdown runs out, the block clears the register and sends a single-cycle timeout request to the interrupt controller, where it sets the OTG timeout source.

A write with the top bit clear cancels any countdown in progress and stores the written word. Every write with the top bit set restarts the countdown from the new count and drops the earlier one. Bits 30 down to 27 are storage only and do not change the timing. The block runs directly on the 60 MHz device clock. Clock-domain crossing and the interrupt controller are outside this block.

Top module: `otg_tmr`

## Requirements
- R1: After reset, rd_data_o reads 0x0000_0000 and timeout_o is low.
- R2: A write (wr_en_i high at a rising edge) stores all 32 bits of wr_data_i. The stored word is on rd_data_o from the cycle after that edge until the next write or an expiry.
- R3: A write with bit 31 set and count N = bits [26:0] arms the timer. If the write is taken at edge k and nothing else is written, timeout_o is high only in the cycle that follows edge k+N+1.
- R4: A count of zero with bit 31 set expires at the first edge after the write: timeout_o is high in the cycle after edge k+1.
- R5: In the cycle where timeout_o is high, rd_data_o reads zero (bit 31 included), and it stays zero until the next write.
- R6: A write with bit 31 set while a countdown is running restarts the count from the newly written value. The earlier count never produces a pulse.
- R7: A write with bit 31 clear cancels any countdown in progress. No pulse follows, and the written word reads back unchanged.
- R8: Bits [30:27] are stored and read back, but they have no effect on the length of the countdown.
- R9: If a write is taken at the same edge at which the running count would expire, the write wins: the register takes the new word and no pulse comes from the old count.
- R10: timeout_o is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Device clock (60 MHz); one countdown tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control/value register |
| wr_data_i | input | 32 | Word to write; bit 31 is the enable, [26:0] is the count |
| rd_data_o | output | 32 | Current register contents |
| timeout_o | output | 1 | Single-cycle timeout request to the interrupt controller |

## Verification
The assertions assume the write strobe and data are stable at each rising edge. They also assume that the only changes to the register come from writes and expiries, so the stored enable bit stays in step with the running countdown. The stimulus drives inputs only at falling edges and holds each write for exactly one cycle. It places writes on chosen edges relative to an expected expiry: well before it, exactly on it, and after it, covering restart, cancel and the write-versus-expiry collision. Counts stay small so that every countdown ends inside the run.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;
  localparam int unsigned TMR_DATA_W = 32;
  localparam int unsigned TMR_CNT_W  = 27;
  localparam int unsigned TMR_EN_BIT = 31;
endpackage

// File: rtl/otg_tmr_cnt.sv
module otg_tmr_cnt #(
  parameter int unsigned CNT_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             cancel_i,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             active_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      active_q <= 1'b1;
    end else if (cancel_i || expire_i) begin
      active_q <= 1'b0;
    end else if (active_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign zero_o   = (cnt_q == '0);

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q != '0 && !load_i && !cancel_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (active_q && cnt_q == $past(load_val_i))); // R6
  AST_CANCEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_i && !load_i) |=> !active_q); // R7
endmodule

// File: rtl/otg_tmr_reg.sv
module otg_tmr_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (wr_i)   q_q <= wr_data_i;
    else if (clr_i)  q_q <= '0;
  end

  assign q_o = q_q;

  AST_WR_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q_q == $past(wr_data_i))); // R2
endmodule

// File: rtl/otg_tmr.sv
module otg_tmr
  import otg_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = TMR_DATA_W,
  parameter int unsigned CNT_W  = TMR_CNT_W,
  parameter int unsigned EN_BIT = TMR_EN_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              timeout_o
);
  logic arm, disarm, expire, active, zero;
  logic timeout_q;

  assign arm    = wr_en_i &&  wr_data_i[EN_BIT];
  assign disarm = wr_en_i && !wr_data_i[EN_BIT];
  // a write in the expiry cycle takes priority over the old count
  assign expire = active && zero && !wr_en_i;

  otg_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (arm),
    .cancel_i   (disarm),
    .expire_i   (expire),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .active_o   (active),
    .zero_o     (zero)
  );

  otg_tmr_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i),
    .wr_data_i (wr_data_i),
    .clr_i     (expire),
    .q_o       (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timeout_q <= 1'b0;
    else         timeout_q <= expire;
  end

  assign timeout_o = timeout_q;

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R10
  AST_CLR_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (rd_data_o == '0)); // R5
  AST_PULSE_FROM_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(rd_data_o[EN_BIT])); // R3
  AST_WR_BEATS_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !timeout_o); // R9
endmodule

// File: tb/otg_tmr_bench.sv
module otg_tmr_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        timeout;

  int vectors = 0;
  int errors  = 0;
  string cur_req = "R1";

  logic [31:0] m_reg = '0;
  logic        m_pend = 1'b0;
  int          m_left = 0;
  logic        m_to = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otg_tmr u_otg_tmr (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .timeout_o (timeout)
  );

  // behavioural reference: pending flag plus remaining ticks
  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = '0; m_pend = 1'b0; m_left = 0; m_to = 1'b0;
    end else begin
      bit fire;
      fire = m_pend && (m_left == 0) && !wr_en;
      m_to = fire;
      if (wr_en) begin
        m_reg  = wr_data;
        m_pend = wr_data[31];
        m_left = int'(wr_data[26:0]);
      end else if (fire) begin
        m_reg  = '0;
        m_pend = 1'b0;
      end else if (m_pend) begin
        m_left = m_left - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (rd_data !== m_reg || timeout !== m_to) begin
        errors++;
        $display("FAIL %s: rd=%h to=%b expected rd=%h to=%b", cur_req, rd_data, timeout, m_reg, m_to);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // after wr() returns: pulse seen at idx N+1, nothing before
  task automatic expect_pulse(input string req, input int n);
    for (int i = 1; i <= n + 2; i++) begin
      @(negedge clk);
      #1;
      chk(req, {31'd0, timeout}, (i == n + 1) ? 32'd1 : 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    idle(3);
    #1;
    chk("R1", rd_data, 32'h0);
    chk("R1", {31'd0, timeout}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2";
    wr(32'h1234_5678);
    #1; chk("R2", rd_data, 32'h1234_5678);
    idle(4);
    #1; chk("R2", rd_data, 32'h1234_5678);

    cur_req = "R3";
    wr(32'h8000_0005);
    expect_pulse("R3", 5);
    #1; chk("R5", rd_data, 32'h0);

    cur_req = "R4";
    wr(32'h8000_0000);
    expect_pulse("R4", 0);

    cur_req = "R6";
    wr(32'h8000_0006);
    idle(2);
    wr(32'h8000_0004);
    expect_pulse("R6", 4);
    idle(8);

    cur_req = "R7";
    wr(32'h8000_0003);
    idle(1);
    wr(32'h0000_0003);
    #1; chk("R7", rd_data, 32'h0000_0003);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      chk("R7", {31'd0, timeout}, 32'h0);
    end
    chk("R7", rd_data, 32'h0000_0003);

    cur_req = "R8";
    wr(32'hF800_0002);
    #1; chk("R8", rd_data, 32'hF800_0002);
    expect_pulse("R8", 2);

    cur_req = "R9";
    wr(32'h8000_0003);
    idle(2);
    wr(32'h8000_0002);
    #1; chk("R9", rd_data, 32'h8000_0002);
    expect_pulse("R9", 2);

    cur_req = "R10";
    wr(32'h8000_0001);
    idle(6);
    wr(32'h8000_0000);
    wr(32'h8000_0000);
    idle(4);
    #1; chk("R10", rd_data, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule